// File: doc/BRIEF.md
# Lockable Shadowed PWM Timer

This block generates one pulse-width-modulated output from a free-running counter. Software programs a period and a duty value, both counted in prescaled clock ticks, and a control word. The control word enables the channel, picks the output level for the duty phase and for the remaining part of the period, and holds a lock bit. Software reaches all of this through a small synchronous register port.

Writes never land in the running waveform directly. Period, duty and both level bits are staged, and the engine copies them into its active set only when the counter wraps at the end of a period. While the lock bit is set, no copy happens, so software can stage period, duty and polarity in any order. Once it clears the lock, all three become active together at the next period boundary.

The engine is a two-state machine. `ST_IDLE` holds the counter at zero and drives the live idle level. The `IDLE_TO_RUN` transition fires when both the enable bit and the continuous bit are set; it loads the staged set and starts the counter at zero. `ST_RUN` counts and reloads at each wrap. The `RUN_TO_IDLE` transition fires when either bit is cleared. The `RUN_HOLD` and `IDLE_HOLD` self-loops cover every other case.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset the counter, period, duty and control registers all read 0, the engine is in `ST_IDLE` and the output is low.
- R2: The engine runs only while control bit 0 (enable) and control bit 1 (continuous) are both 1. Otherwise the counter reads 0 and the output equals control bit 4.
- R3: While running, the counter advances by one on each prescaler tick, one tick every PRESCALE clocks. From period−1 it wraps to 0, and with period 0 or 1 it stays at 0.
- R4: While running, the output takes the active duty level while counter < duty and the active idle level otherwise, so the duty phase comes first in each period. Control bit 3 is the duty-phase level and control bit 4 is the idle level (1 = high, 0 = low).
- R5: A duty value of period or more gives a constant duty level while running. A duty of 0 gives a constant idle level.
- R6: With control bit 6 (lock) clear, new period, duty and level bits become active only at a counter wrap, never in the middle of a period.
- R7: While control bit 6 is 1, no wrap copies staged values into the active set, and the waveform keeps its previous period, duty and levels.
- R8: After control bit 6 is cleared, the staged period, duty and level bits all become active together at the next wrap.
- R9: A read at offset 0x0 returns the live counter. Reads at 0x4 (period), 0x8 (duty) and 0xC (control) return the last value written. Any other offset reads 0.
- R10: On the `IDLE_TO_RUN` transition the staged set is loaded and the counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The bench changes duty and period in the middle of a period. A design that applied them at once would show a short or stretched pulse before the wrap. It stages a full new configuration under lock and then clears the lock together with a polarity inversion. A design that leaked values through the lock, or activated them one at a time, would give a period whose level or length differs from the model. It also runs duty equal to zero and duty above period, where a comparison that is off by one gives a stray one-tick pulse or a one-tick gap. It uses a divide-by-2 prescaler, where a counter that advanced on every clock would run twice as fast.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
    localparam int CW = 32;
    localparam int AW = 4;

    localparam logic [AW-1:0] OFS_CNT  = 4'h0;
    localparam logic [AW-1:0] OFS_PER  = 4'h4;
    localparam logic [AW-1:0] OFS_DUTY = 4'h8;
    localparam logic [AW-1:0] OFS_CTRL = 4'hC;

    localparam int B_EN       = 0;
    localparam int B_CONT     = 1;
    localparam int B_LVL_DUTY = 3;
    localparam int B_LVL_IDLE = 4;
    localparam int B_LOCK     = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;

    typedef struct packed {
        logic [CW-1:0] per;
        logic [CW-1:0] duty;
        logic          lvl_duty;
        logic          lvl_idle;
    } wave_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_shadow_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] per_q,
    output logic [CW-1:0] duty_q,
    output logic [CW-1:0] ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (addr == OFS_PER)  per_q  <= wdata;
            if (addr == OFS_DUTY) duty_q <= wdata;
            if (addr == OFS_CTRL) ctrl_q <= wdata;
        end
    end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            assign tick = run && (pre_q == PW'(PRESCALE - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      pre_q <= '0;
                else if (!run)   pre_q <= '0;
                else if (tick)   pre_q <= '0;
                else             pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_shadow_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          lock,
    input  logic          tick,
    input  logic          live_idle_lvl,
    input  wave_cfg_t     staged,
    output pwm_state_e    st,
    output logic [CW-1:0] cnt,
    output wave_cfg_t     act,
    output logic          pwm_out
);
    pwm_state_e nxt;
    logic       wrap;

    assign wrap = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, act.per});

    always_comb begin
        unique case (st)
            ST_IDLE: nxt = run_req ? ST_RUN : ST_IDLE;
            ST_RUN:  nxt = run_req ? ST_RUN : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            act <= '0;
        end else begin
            st <= nxt;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (run_req) act <= staged;
                end
                ST_RUN: begin
                    if (!run_req) begin
                        cnt <= '0;
                    end else if (wrap) begin
                        cnt <= '0;
                        if (!lock) act <= staged;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE: pwm_out = live_idle_lvl;
            ST_RUN:  pwm_out = (cnt < act.duty) ? act.lvl_duty : act.lvl_idle;
            default: pwm_out = live_idle_lvl;
        endcase
    end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_shadow_pkg::*;
#(
    parameter int PRESCALE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          pwm_out
);
    logic [CW-1:0] per_q, duty_q, ctrl_q, cnt;
    pwm_state_e    st;
    wave_cfg_t     staged, act;
    logic          tick, run_req;

    pwm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .per_q(per_q), .duty_q(duty_q), .ctrl_q(ctrl_q)
    );

    assign run_req = ctrl_q[B_EN] & ctrl_q[B_CONT];
    assign staged  = '{per: per_q, duty: duty_q,
                       lvl_duty: ctrl_q[B_LVL_DUTY], lvl_idle: ctrl_q[B_LVL_IDLE]};

    pwm_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(st == ST_RUN), .tick(tick)
    );

    pwm_engine u_engine (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .lock(ctrl_q[B_LOCK]),
        .tick(tick), .live_idle_lvl(ctrl_q[B_LVL_IDLE]), .staged(staged),
        .st(st), .cnt(cnt), .act(act), .pwm_out(pwm_out)
    );

    always_comb begin
        case (reg_addr)
            OFS_CNT:  reg_rdata = cnt;
            OFS_PER:  reg_rdata = per_q;
            OFS_DUTY: reg_rdata = duty_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk
    import pwm_shadow_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input pwm_state_e    st,
    input logic [CW-1:0] cnt,
    input wave_cfg_t     act,
    input logic [CW-1:0] ctrl_q,
    input logic          pwm_out
);
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && act.per != '0) |-> cnt < act.per); // R3

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> cnt == '0); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> pwm_out == ctrl_q[B_LVL_IDLE]); // R2

    AST_NO_MIDPERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_RUN && cnt != '0) |->
            ($stable(act.per) && $stable(act.duty) && $stable(act.lvl_duty))); // R6

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_RUN && $past(ctrl_q[B_LOCK])) |->
            ($stable(act.per) && $stable(act.duty) && $stable(act.lvl_idle))); // R7
endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .act(act),
    .ctrl_q(ctrl_q), .pwm_out(pwm_out)
);

// File: tb/pwm_shadow_timer_bench.sv
module pwm_shadow_timer_bench;
    localparam int PRE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwm_shadow_timer #(.PRESCALE(PRE)) u_pwm_shadow_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    // behavioural reference state
    logic [31:0] m_per, m_duty, m_ctrl, m_cnt, a_per, a_duty;
    logic        a_pd, a_pi, m_run, m_req, m_lk;
    int          m_pre;

    task automatic m_load();
        a_per = m_per; a_duty = m_duty; a_pd = m_ctrl[3]; a_pi = m_ctrl[4];
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_per = 0; m_duty = 0; m_ctrl = 0; m_cnt = 0; m_pre = 0;
            a_per = 0; a_duty = 0; a_pd = 0; a_pi = 0; m_run = 0;
        end else begin
            m_req = m_ctrl[0] && m_ctrl[1];
            m_lk  = m_ctrl[6];
            if (!m_run) begin
                m_cnt = 0; m_pre = 0;
                if (m_req) begin m_run = 1; m_load(); end
            end else if (!m_req) begin
                m_run = 0; m_cnt = 0; m_pre = 0;
            end else if (m_pre == PRE - 1) begin
                m_pre = 0;
                if (longint'(m_cnt) + 1 >= longint'(a_per)) begin
                    m_cnt = 0;
                    if (!m_lk) m_load();
                end else m_cnt = m_cnt + 1;
            end else m_pre = m_pre + 1;
            if (reg_wr) begin
                if (reg_addr == 4'h4) m_per  = reg_wdata;
                if (reg_addr == 4'h8) m_duty = reg_wdata;
                if (reg_addr == 4'hC) m_ctrl = reg_wdata;
            end
        end
    end

    function automatic logic exp_out();
        if (!m_run) return m_ctrl[4];
        return (m_cnt < a_duty) ? a_pd : a_pi;
    endfunction

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'h0: return m_cnt;
            4'h4: return m_per;
            4'h8: return m_duty;
            4'hC: return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    task automatic cyc();
        @(negedge clk);
        n_cmp++;
        if (pwm_out !== exp_out()) begin
            n_bad++;
            $display("FAIL %s pwm_out actual=%0b expected=%0b t=%0t", cur_req, pwm_out, exp_out(), $time);
        end
        n_cmp++;
        if (reg_rdata !== exp_rd(reg_addr)) begin
            n_bad++;
            $display("FAIL %s rdata@%0h actual=%0h expected=%0h t=%0t", cur_req, reg_addr, reg_rdata, exp_rd(reg_addr), $time);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a);
        reg_addr = a; cyc(); reg_addr = 4'h0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        // R1: reset values at every offset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h0); rd(4'h4); rd(4'h8); rd(4'hC);
        // R10 / R3 / R4: start with period 5, duty 2, high duty level
        cur_req = "R10";
        wr(4'h4, 32'd5); wr(4'h8, 32'd2); wr(4'hC, 32'h0B);
        cur_req = "R3"; run(12);
        cur_req = "R4"; run(12);
        // R2: enable without continuous, then continuous without enable
        cur_req = "R2";
        wr(4'hC, 32'h09); run(6);
        wr(4'hC, 32'h1A); run(6);
        wr(4'hC, 32'h0B); run(5);
        // R6: mid-period duty and period changes wait for the wrap
        cur_req = "R6";
        run(3); wr(4'h8, 32'd4); run(4); wr(4'h4, 32'd7); run(20);
        // R5: duty above period, then duty zero
        cur_req = "R5";
        wr(4'h8, 32'd9); run(20);
        wr(4'h8, 32'd0); run(20);
        // R7: lock, stage a new set, waveform unchanged
        cur_req = "R7";
        wr(4'h8, 32'd3); run(16);
        wr(4'hC, 32'h4B); wr(4'h4, 32'd3); wr(4'h8, 32'd1); run(30);
        // R8: unlock together with inverted polarity
        cur_req = "R8";
        wr(4'hC, 32'h13); run(24);
        // R9: readback and live counter
        cur_req = "R9";
        rd(4'h4); rd(4'h8); rd(4'hC); rd(4'h2);
        reg_addr = 4'h0; run(8);
        summary();
    end
endmodule